// File: doc/BRIEF.md
# Configuration Access Translator

This block turns configuration-space requests (bus number, device number, function number, register offset and access size) into aligned 32-bit word transfers on an external expansion bus. Requests on bus 0 address a device directly through a one-hot select line. Requests on any other bus are forwarded with the bus and device numbers encoded in the address. A window register accompanies every transfer. It carries a code for the addressing type and, for direct requests, the top part of the one-hot device select.

Reads always fetch the whole aligned word and return the requested byte lane, shifted down and zero-extended. Byte and halfword writes use a read-modify-write of the containing word. Full-word writes go out as a single store. Unsupported sizes, unreachable devices and bus errors each complete with a status code. The requester sees a valid/ready handshake, at most one request in flight, and a one-cycle done pulse that carries the status and the read data.

Top module: `cfgx_translator`

## Requirements
- R1: After reset, `req_ready` is 1, and `done`, `bus_req` and `win_reg` are all 0.
- R2: A request whose size is not 1, 2 or 4 completes with status 1 (invalid). It makes no bus transfer and leaves `win_reg` unchanged.
- R3: A request completes with status 2 (not found), with no bus transfer and with `win_reg` unchanged, in either of these cases: `card_mode` is 1 and the device number is above 1; or the bus number is 0 and the device number is 16 or more.
- R4: On bus 0, `bus_addr` is built as follows. Bits 25:16 hold bits 25:16 of (1 << (device+16)). Bits 10:8 hold the function number. The offset is placed with its two low bits cleared. `win_reg` is 0x2 ORed with bits 31:26 of the same one-hot value.
- R5: On a nonzero bus, `bus_addr` is built as follows. Bits 23:16 hold the bus number, bits 15:11 the device number and bits 10:8 the function number. The offset is placed with its two low bits cleared. `win_reg` is 0x3.
- R6: A successful read returns the fetched word shifted right by 8 times offset[1:0], then truncated to the requested size and zero-extended. Status is 0 (ok).
- R7: A 1- or 2-byte write makes one bus read and then one bus write to the same word. The write data is the word read, with the lane of size 0xFF or 0xFFFF at bit 8*offset[1:0] replaced by the new data. Bits that fall beyond bit 31 are dropped.
- R8: A 4-byte write makes exactly one bus write of `req_wdata` and no read.
- R9: A transfer acknowledged together with `bus_err` completes the request with status 2 and read data 0. An error on the read half of a read-modify-write suppresses the write.
- R10: `req_ready` is low from acceptance until the done pulse. `done` lasts exactly one cycle.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_write`, `bus_addr` and `bus_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_mode | input | 1 | Restricted mode: only devices 0 and 1 are reachable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Translator idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 invalid, 2 not found |
| done_rdata | output | 32 | Read data, right-aligned |
| bus_req | output | 1 | Word transfer request |
| bus_write | output | 1 | Transfer direction |
| bus_addr | output | 32 | Word address of the transfer |
| bus_wdata | output | 32 | Word write data |
| bus_ack | input | 1 | Transfer complete |
| bus_err | input | 1 | Transfer failed, valid with bus_ack |
| bus_rdata | input | 32 | Word read data, valid with bus_ack |
| win_reg | output | 32 | Window register value |

## Verification
The assertions rely on three things from the environment. The expansion bus raises `bus_ack` only while `bus_req` is high. It drives `bus_err` and `bus_rdata` only in the acknowledge cycle. The requester changes nothing while `req_ready` is low. The bench bus model acknowledges each transfer once, after a latency of 0 to 2 cycles chosen per vector, and can raise an error on either the read or the write phase. Requests are issued only on idle cycles and dropped right after acceptance.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [1:0] {
        CS_OK       = 2'd0,
        CS_INVALID  = 2'd1,
        CS_NOTFOUND = 2'd2
    } cfgx_status_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_READ = 2'd1,
        PH_WRITE = 2'd2,
        PH_RESP = 2'd3
    } cfgx_phase_e;

endpackage

// File: rtl/cfgx_addr_gen.sv
module cfgx_addr_gen #(
    parameter int          ADDR_W    = 32,
    parameter int          BUS_W     = 8,
    parameter int          DEV_W     = 5,
    parameter int          FUNC_W    = 3,
    parameter int          OFFH_W    = 6,
    parameter int          LO_W      = 2,
    parameter int          SIZE_W    = 3,
    parameter int          SLOT_MAX  = 16,
    parameter int          SEL_BASE  = 16,
    parameter logic [31:0] WIN_MASK  = 32'hFC00_0000,
    parameter logic [31:0] CODE_T0   = 32'h0000_0002,
    parameter logic [31:0] CODE_T1   = 32'h0000_0003
) (
    input  logic [BUS_W-1:0]  bus_num,
    input  logic [DEV_W-1:0]  dev_num,
    input  logic [FUNC_W-1:0] func_num,
    input  logic [OFFH_W-1:0] off_hi,
    input  logic [SIZE_W-1:0] size,
    input  logic              card_mode,
    output logic              size_ok,
    output logic              dev_ok,
    output logic [ADDR_W-1:0] win_val,
    output logic [ADDR_W-1:0] acc_addr
);
    localparam int BUS_POS  = 16;
    localparam int DEV_POS  = 11;
    localparam int FUNC_POS = 8;

    logic              remote;
    logic [ADDR_W-1:0] sel_d;
    logic [ADDR_W-1:0] common_d;

    always_comb begin
        remote   = (bus_num != '0);
        size_ok  = (size == SIZE_W'(1)) || (size == SIZE_W'(2)) || (size == SIZE_W'(4));
        dev_ok   = !(card_mode && (dev_num > DEV_W'(1)))
                   && (remote || (32'(dev_num) < SLOT_MAX));
        sel_d    = ADDR_W'(1) << (32'(dev_num) + SEL_BASE);
        common_d = (ADDR_W'(func_num) << FUNC_POS) | (ADDR_W'(off_hi) << LO_W);
        if (remote) begin
            win_val  = CODE_T1;
            acc_addr = (ADDR_W'(bus_num) << BUS_POS)
                     | (ADDR_W'(dev_num) << DEV_POS) | common_d;
        end else begin
            win_val  = CODE_T0 | (sel_d & WIN_MASK);
            acc_addr = (sel_d & ~WIN_MASK) | common_d;
        end
    end

endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane #(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3,
    parameter int LO_W   = 2
) (
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] new_data,
    input  logic [LO_W-1:0]   lo,
    input  logic [SIZE_W-1:0] size,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] merged
);
    localparam int LANES = DATA_W / 8;

    logic              full;
    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] src;

    always_comb begin
        full      = (32'(size) >= LANES);
        size_mask = full ? '1 : ((DATA_W'(1) << (32'(size) * 8)) - DATA_W'(1));
        rd_val    = (word >> {lo, 3'b000}) & size_mask;
        src       = full ? new_data : (new_data << {lo, 3'b000});
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic hit;
        always_comb begin
            hit = full || ((b >= 32'(lo)) && (b < 32'(lo) + 32'(size)));
            merged[b*8 +: 8] = hit ? src[b*8 +: 8] : word[b*8 +: 8];
        end
    end

endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator #(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int          BUS_W    = 8,
    parameter int          DEV_W    = 5,
    parameter int          FUNC_W   = 3,
    parameter int          OFF_W    = 8,
    parameter int          SIZE_W   = 3,
    parameter int          SLOT_MAX = 16,
    parameter int          SEL_BASE = 16,
    parameter logic [31:0] WIN_MASK = 32'hFC00_0000,
    parameter logic [31:0] CODE_T0  = 32'h0000_0002,
    parameter logic [31:0] CODE_T1  = 32'h0000_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [1:0]        done_status,
    output logic [DATA_W-1:0] done_rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] win_reg
);
    import cfgx_pkg::*;

    localparam int          LO_W      = $clog2(DATA_W / 8);
    localparam int          OFFH_W    = OFF_W - LO_W;
    localparam logic [31:0] SEL_FIELD = ~WIN_MASK & 32'hFFFF_0000;

    typedef struct packed {
        cfgx_phase_e       phase;
        logic              write;
        logic [LO_W-1:0]   lo;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] wdata;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] win;
        logic [DATA_W-1:0] bwdata;
        logic [DATA_W-1:0] rdata;
        cfgx_status_e      status;
    } xlate_t;

    xlate_t xl_d, xl_q;

    logic              size_ok, dev_ok;
    logic [ADDR_W-1:0] gen_win, gen_addr;
    logic [DATA_W-1:0] lane_rd, lane_merged;

    cfgx_addr_gen #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W),
        .OFFH_W(OFFH_W), .LO_W(LO_W), .SIZE_W(SIZE_W), .SLOT_MAX(SLOT_MAX),
        .SEL_BASE(SEL_BASE), .WIN_MASK(WIN_MASK), .CODE_T0(CODE_T0), .CODE_T1(CODE_T1)
    ) u_addr (
        .bus_num  (req_bus),
        .dev_num  (req_dev),
        .func_num (req_func),
        .off_hi   (req_off[OFF_W-1:LO_W]),
        .size     (req_size),
        .card_mode(card_mode),
        .size_ok  (size_ok),
        .dev_ok   (dev_ok),
        .win_val  (gen_win),
        .acc_addr (gen_addr)
    );

    cfgx_lane #(
        .DATA_W(DATA_W), .SIZE_W(SIZE_W), .LO_W(LO_W)
    ) u_lane (
        .word    (bus_rdata),
        .new_data(xl_q.wdata),
        .lo      (xl_q.lo),
        .size    (xl_q.size),
        .rd_val  (lane_rd),
        .merged  (lane_merged)
    );

    always_comb begin
        xl_d = xl_q;
        case (xl_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    xl_d.write = req_write;
                    xl_d.lo    = req_off[LO_W-1:0];
                    xl_d.size  = req_size;
                    xl_d.wdata = req_wdata;
                    xl_d.rdata = '0;
                    if (!size_ok) begin
                        xl_d.status = CS_INVALID;
                        xl_d.phase  = PH_RESP;
                    end else if (!dev_ok) begin
                        xl_d.status = CS_NOTFOUND;
                        xl_d.phase  = PH_RESP;
                    end else begin
                        xl_d.win  = gen_win;
                        xl_d.addr = gen_addr;
                        if (req_write && (32'(req_size) == DATA_W / 8)) begin
                            xl_d.bwdata = req_wdata;
                            xl_d.phase  = PH_WRITE;
                        end else begin
                            xl_d.phase = PH_READ;
                        end
                    end
                end
            end
            PH_READ: begin
                if (bus_ack) begin
                    if (bus_err) begin
                        xl_d.status = CS_NOTFOUND;
                        xl_d.phase  = PH_RESP;
                    end else if (!xl_q.write) begin
                        xl_d.rdata  = lane_rd;
                        xl_d.status = CS_OK;
                        xl_d.phase  = PH_RESP;
                    end else begin
                        xl_d.bwdata = lane_merged;
                        xl_d.phase  = PH_WRITE;
                    end
                end
            end
            PH_WRITE: begin
                if (bus_ack) begin
                    xl_d.status = bus_err ? CS_NOTFOUND : CS_OK;
                    xl_d.phase  = PH_RESP;
                end
            end
            default: begin
                xl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_q <= '0;
        end else begin
            xl_q <= xl_d;
        end
    end

    always_comb begin
        req_ready   = (xl_q.phase == PH_IDLE);
        done        = (xl_q.phase == PH_RESP);
        done_status = xl_q.status;
        done_rdata  = xl_q.rdata;
        bus_req     = (xl_q.phase == PH_READ) || (xl_q.phase == PH_WRITE);
        bus_write   = (xl_q.phase == PH_WRITE);
        bus_addr    = xl_q.addr;
        bus_wdata   = xl_q.bwdata;
        win_reg     = xl_q.win;
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_write) && $stable(bus_addr) && $stable(bus_wdata)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R10

    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_req); // R10

    AST_INVALID_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        done && (done_status == 2'd1) |-> $past(req_ready)); // R2

    AST_WIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ((win_reg & ~WIN_MASK) == CODE_T0) || ((win_reg & ~WIN_MASK) == CODE_T1)); // R4

    AST_T0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && ((win_reg & ~WIN_MASK) == CODE_T0)
        |-> ($countones(win_reg & WIN_MASK) + $countones(bus_addr & SEL_FIELD)) == 1); // R4

    AST_T1_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && ((win_reg & ~WIN_MASK) == CODE_T1) |-> (win_reg & WIN_MASK) == '0); // R5

endmodule

// File: tb/cfgx_translator_tb.sv
module cfgx_translator_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_off = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [1:0]  done_status;
    logic [31:0] done_rdata;
    logic        bus_req, bus_write;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic [31:0] win_reg;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    cfgx_translator u_dut (
        .clk(clk), .rst_n(rst_n), .card_mode(card_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .done(done), .done_status(done_status), .done_rdata(done_rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .win_reg(win_reg)
    );

    // Expansion bus model
    logic [31:0] mem [logic [31:0]];
    int          lat = 0;
    int          err_mode = 0;
    int          wait_cnt = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] seen_win = '0;

    function automatic logic [31:0] memget(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : (a ^ 32'hA5A5_5A5A);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack  <= 1'b0;
            bus_err  <= 1'b0;
            wait_cnt <= 0;
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
            if (bus_req && bus_ack) begin
                if (bus_write) begin
                    wr_cnt <= wr_cnt + 1;
                    if (!bus_err) mem[bus_addr] = bus_wdata;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                end
            end else if (bus_req) begin
                if (wait_cnt >= lat) begin
                    bus_ack   <= 1'b1;
                    bus_err   <= (err_mode == 1 && !bus_write) || (err_mode == 2 && bus_write);
                    bus_rdata <= memget(bus_addr);
                    seen_win  <= win_reg;
                    wait_cnt  <= 0;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    typedef struct packed {
        logic        wr;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  func;
        logic [7:0]  off;
        logic [2:0]  size;
        logic [31:0] wdata;
        logic        card;
        logic [1:0]  lat;
        logic [1:0]  err;
        logic [1:0]  exp_st;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'd0, 5'd0,  3'd0, 8'h00, 3'd4, 32'h0,         1'b0, 2'd0, 2'd0, 2'd0},
        '{1'b0, 8'd0, 5'd3,  3'd1, 8'h0E, 3'd2, 32'h0,         1'b0, 2'd1, 2'd0, 2'd0},
        '{1'b0, 8'd0, 5'd12, 3'd2, 8'h07, 3'd1, 32'h0,         1'b0, 2'd2, 2'd0, 2'd0},
        '{1'b0, 8'd5, 5'd9,  3'd4, 8'h40, 3'd4, 32'h0,         1'b0, 2'd0, 2'd0, 2'd0},
        '{1'b1, 8'd0, 5'd2,  3'd0, 8'h05, 3'd1, 32'h0000_005A, 1'b0, 2'd0, 2'd0, 2'd0},
        '{1'b0, 8'd0, 5'd2,  3'd0, 8'h04, 3'd4, 32'h0,         1'b0, 2'd0, 2'd0, 2'd0},
        '{1'b1, 8'd0, 5'd15, 3'd7, 8'h12, 3'd2, 32'h0000_BEEF, 1'b0, 2'd1, 2'd0, 2'd0},
        '{1'b1, 8'd7, 5'd31, 3'd3, 8'h20, 3'd4, 32'hDEAD_BEEF, 1'b0, 2'd2, 2'd0, 2'd0},
        '{1'b1, 8'd1, 5'd4,  3'd0, 8'h0B, 3'd2, 32'h0000_1234, 1'b0, 2'd0, 2'd0, 2'd0},
        '{1'b0, 8'd0, 5'd1,  3'd0, 8'h00, 3'd3, 32'h0,         1'b0, 2'd0, 2'd0, 2'd1},
        '{1'b1, 8'd0, 5'd1,  3'd0, 8'h00, 3'd0, 32'h1,         1'b0, 2'd0, 2'd0, 2'd1},
        '{1'b0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 32'h0,         1'b0, 2'd0, 2'd0, 2'd2},
        '{1'b0, 8'd0, 5'd2,  3'd0, 8'h00, 3'd4, 32'h0,         1'b1, 2'd0, 2'd0, 2'd2},
        '{1'b0, 8'd0, 5'd1,  3'd1, 8'h08, 3'd4, 32'h0,         1'b1, 2'd0, 2'd0, 2'd0},
        '{1'b0, 8'd3, 5'd20, 3'd0, 8'h10, 3'd4, 32'h0,         1'b0, 2'd1, 2'd1, 2'd2},
        '{1'b1, 8'd0, 5'd6,  3'd0, 8'h31, 3'd1, 32'h0000_0077, 1'b0, 2'd0, 2'd1, 2'd2},
        '{1'b1, 8'd0, 5'd6,  3'd0, 8'h30, 3'd4, 32'h1111_2222, 1'b0, 2'd0, 2'd2, 2'd2},
        '{1'b0, 8'd0, 5'd5,  3'd0, 8'h09, 3'd4, 32'h0,         1'b0, 2'd2, 2'd0, 2'd0}
    };

    function automatic logic [31:0] ref_addr(input vec_t v);
        logic [63:0] sel;
        logic [31:0] a;
        sel = 64'd1 << (int'(v.dev) + 16);
        a = ({24'd0, v.off} & 32'hFFFF_FFFC) | ({29'd0, v.func} << 8);
        if (v.bus == 8'd0) a = a | (sel[31:0] & 32'h03FF_0000);
        else a = a | ({24'd0, v.bus} << 16) | ({27'd0, v.dev} << 11);
        return a;
    endfunction

    function automatic logic [31:0] ref_win(input vec_t v);
        logic [63:0] sel;
        sel = 64'd1 << (int'(v.dev) + 16);
        if (v.bus == 8'd0) return 32'h2 | (sel[31:0] & 32'hFC00_0000);
        return 32'h3;
    endfunction

    task automatic run(input vec_t v, input int idx);
        logic [31:0] ea, pre, win0, exp_rd, exp_mem, msk;
        int          rd0, wr0, n, sh, exp_r, exp_w;
        bit          sz_ok, dv_ok, use_bus, sub;
        sz_ok   = (v.size == 3'd1) || (v.size == 3'd2) || (v.size == 3'd4);
        dv_ok   = !(v.card && v.dev > 5'd1) && ((v.bus != 8'd0) || (v.dev < 5'd16));
        use_bus = sz_ok && dv_ok;
        sub     = (v.size != 3'd4);
        sh      = 8 * int'(v.off[1:0]);
        ea      = ref_addr(v);
        pre     = memget(ea);
        win0    = win_reg;
        rd0     = rd_cnt;
        wr0     = wr_cnt;
        exp_r   = (use_bus && (!v.wr || sub)) ? 1 : 0;
        exp_w   = (use_bus && v.wr && !(v.err == 2'd1 && sub)) ? 1 : 0;
        lat       = int'(v.lat);
        err_mode  = int'(v.err);
        card_mode = v.card;
        req_write = v.wr;
        req_bus   = v.bus;
        req_dev   = v.dev;
        req_func  = v.func;
        req_off   = v.off;
        req_size  = v.size;
        req_wdata = v.wdata;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            chk(!req_ready, "R10 ready low while busy", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            n++;
        end
        chk(done, "R10 done reached", {31'd0, done}, 32'd1);
        // status: R2 invalid size, R3 unreachable device, R9 bus error
        chk(done_status == v.exp_st, !sz_ok ? "R2 status" : (!dv_ok ? "R3 status" : "R9 status"),
            {30'd0, done_status}, {30'd0, v.exp_st});
        msk = (v.size == 3'd1) ? 32'hFF : ((v.size == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF);
        exp_rd = (!v.wr && v.exp_st == 2'd0) ? ((pre >> sh) & msk) : 32'd0;
        chk(done_rdata == exp_rd, "R6 read data", done_rdata, exp_rd);
        chk(rd_cnt - rd0 == exp_r, v.wr ? "R7 read count" : "R6 read count", rd_cnt - rd0, exp_r);
        chk(wr_cnt - wr0 == exp_w, sub ? "R7 write count" : "R8 write count", wr_cnt - wr0, exp_w);
        if (use_bus) begin
            chk(seen_win == ref_win(v), v.bus == 8'd0 ? "R4 window" : "R5 window", seen_win, ref_win(v));
            chk(win_reg == ref_win(v), v.bus == 8'd0 ? "R4 window port" : "R5 window port", win_reg, ref_win(v));
            if (!sub) exp_mem = v.wdata;
            else exp_mem = (pre & ~(msk << sh)) | ((v.wdata << sh) & (msk << sh));
            if (!(v.wr && v.exp_st == 2'd0)) exp_mem = pre;
            chk(memget(ea) == exp_mem, v.wr ? (sub ? "R7 merged word" : "R8 full word") : "R9 memory unchanged",
                memget(ea), exp_mem);
        end else begin
            chk(win_reg == win0, dv_ok ? "R2 window kept" : "R3 window kept", win_reg, win0);
        end
        @(negedge clk);
        chk(!done && req_ready, "R10 single done pulse", {30'd0, done, req_ready}, 32'd1);
        if (idx < 0) $display("vector %0d", idx);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk(!done, "R1 done after reset", {31'd0, done}, 32'd0);
        chk(!bus_req, "R1 bus idle after reset", {31'd0, bus_req}, 32'd0);
        chk(win_reg == 32'd0, "R1 window after reset", win_reg, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i], i);
        end

        // R11: long latency with a write, bus outputs held (also covered by AST_BUS_HOLD)
        lat = 3;
        err_mode = 0;
        card_mode = 1'b0;
        req_write = 1'b1;
        req_bus = 8'd2;
        req_dev = 5'd7;
        req_func = 3'd1;
        req_off = 8'h24;
        req_size = 3'd4;
        req_wdata = 32'hCAFE_F00D;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        begin
            logic [31:0] a0, d0;
            a0 = bus_addr;
            d0 = bus_wdata;
            chk(bus_req && bus_write, "R11 request up", {30'd0, bus_req, bus_write}, 32'd3);
            @(negedge clk);
            @(negedge clk);
            chk(bus_req && bus_addr == a0, "R11 address held", bus_addr, a0);
            chk(bus_wdata == d0 && d0 == 32'hCAFE_F00D, "R11 data held", bus_wdata, 32'hCAFE_F00D);
        end
        for (int k = 0; k < 10 && !done; k++) @(negedge clk);
        chk(done && done_status == 2'd0, "R8 long write done", {30'd0, done_status}, 32'd0);
        @(negedge clk);

        // R1: reset in the middle of a transfer
        lat = 3;
        req_write = 1'b0;
        req_bus = 8'd0;
        req_dev = 5'd1;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(req_ready && !bus_req && !done, "R1 mid-transfer reset", {29'd0, req_ready, bus_req, done}, 32'd4);
        chk(win_reg == 32'd0, "R1 window cleared", win_reg, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule